// File: doc/BRIEF.md
# Exception entry sequencer

This block carries out the hardware side of taking an exception in a 32-bit processor core. The exception selection logic hands it one request. The request carries an 8-bit vector number, the PC of the faulting instruction, the PC of the following instruction, the 16-bit status register, the supervisor stack pointer and the vector base register. The block first rounds the stack pointer down to a longword boundary. It then writes a two-longword frame below that boundary over a simple 32-bit memory port. After the frame it reads the handler address from the vector table. Finally it hands the fetch unit a one-cycle redirect, together with the new stack pointer value.

The FSM states are ST_IDLE, ST_ALIGN, ST_PUSH_PC, ST_PUSH_SR, ST_READ_VECTOR and ST_REDIRECT. The transitions are:

- ST_IDLE to ST_ALIGN on accepting a request with a legal vector. A request with an illegal vector keeps the FSM in ST_IDLE.
- ST_ALIGN to ST_PUSH_PC unconditionally.
- ST_PUSH_PC to ST_PUSH_SR when `mem_ready` is high. Otherwise the FSM stays in ST_PUSH_PC.
- ST_PUSH_SR to ST_READ_VECTOR when `mem_ready` is high.
- ST_READ_VECTOR to ST_REDIRECT when `mem_ready` is high.
- ST_REDIRECT to ST_IDLE unconditionally.

The block does not accept a request in any state other than ST_IDLE.

The table base keeps only the top 12 bits of the base register, since the table sits on a 1 MiB boundary. Each table entry is four bytes, indexed by the vector number.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `mem_req`, `redirect_valid` and `vec_error` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is 0 from the cycle after acceptance until ST_REDIRECT has ended. Requests presented during that time are ignored and do not change any frame word, address or redirect.
- R3: The first access writes (`mem_we`=1) the stacked PC to address A-4. A is `ssp_in` with its two low bits cleared.
- R4: The stacked PC is `next_pc` for vectors 9, 12 and 24 and for vectors 64 to 102. It is `fault_pc` for every other legal vector (2 to 63).
- R5: The second access writes the frame word to A-8. The frame word has bits [31:28] = 4 + `ssp_in`[1:0], bits [27:24] = 0, bits [23:16] = vector number and bits [15:0] = status register.
- R6: The third access is a read (`mem_we`=0) at address {`vbr_in`[31:20], 10'b0, vector, 2'b00}. The low 20 bits of `vbr_in` have no effect.
- R7: An access that is not yet acknowledged keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ready` is 1. Every access address is a multiple of 4.
- R8: One cycle after the read completes, `redirect_valid` is 1 for exactly one cycle. In that cycle `redirect_pc` equals the data read and `ssp_out` equals A-8. `req_ready` is 1 in the following cycle.
- R9: A request for vector 0, vector 1 or vectors 103 to 255 produces a one-cycle `vec_error` pulse in the cycle after acceptance. It makes no memory access and no redirect, and leaves the block ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vector | input | 8 | Vector number of the request |
| fault_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | PC of the next instruction |
| sr_in | input | 16 | Status register at the time of the exception |
| ssp_in | input | 32 | Supervisor stack pointer |
| vbr_in | input | 32 | Vector base register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when `mem_ready` is 1 |
| mem_ready | input | 1 | Access completes in this cycle |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Handler address |
| ssp_out | output | 32 | Updated stack pointer, valid with `redirect_valid` |
| vec_error | output | 1 | Illegal vector pulse |

## Verification
The hardest situation to reach from the ports is a second request arriving while a frame is still being written and the memory is stalling. Reaching it needs a busy sequencer, a held-off `mem_ready` and a competing request with different field values, all at the same time. The bench sweeps every vector number. For each one it varies the stack misalignment, the number of wait states and the base register's ignored low bits. On a subset of vectors it holds a different request high for the whole busy period. It then confirms that the frame words, the table address and the redirect all still reflect the first request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN       = 32;
    localparam int VEC_W      = 8;
    localparam int SR_W       = 16;
    localparam int FMT_W      = 4;
    localparam int WORD_BYTES = XLEN / 8;
    localparam int ALIGN_BITS = $clog2(WORD_BYTES);
    localparam int BASE_LSB   = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_READ_VECTOR,
        ST_REDIRECT
    } seq_state_e;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [XLEN-1:0]  pc;
        logic [SR_W-1:0]  sr;
        logic [XLEN-1:0]  ssp;
        logic [XLEN-1:0]  vbr;
    } exc_req_t;
endpackage

// File: rtl/exc_pc_select.sv
module exc_pc_select
    import exc_entry_pkg::*;
#(
    parameter int FIRST_PERIPH = 64,
    parameter int LAST_VALID   = 102
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [XLEN-1:0]  fault_pc,
    input  logic [XLEN-1:0]  next_pc,
    output logic [XLEN-1:0]  stacked_pc,
    output logic             vec_bad
);
    localparam int FIRST_STACKED = 2;

    logic use_next;

    always_comb begin
        use_next = 1'b0;
        unique case (int'(vec))
            9, 12, 24: use_next = 1'b1;
            default:   use_next = (int'(vec) >= FIRST_PERIPH) && (int'(vec) <= LAST_VALID);
        endcase
        vec_bad    = (int'(vec) < FIRST_STACKED) || (int'(vec) > LAST_VALID);
        stacked_pc = use_next ? next_pc : fault_pc;
    end
endmodule

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0]  ssp,
    input  logic [XLEN-1:0]  vbr,
    input  logic [VEC_W-1:0] vec,
    input  logic [SR_W-1:0]  sr,
    output logic [XLEN-1:0]  pc_slot,
    output logic [XLEN-1:0]  fv_slot,
    output logic [XLEN-1:0]  fv_word,
    output logic [XLEN-1:0]  vec_addr
);
    localparam int PAD_W  = XLEN - FMT_W - VEC_W - SR_W;
    localparam int IDX_HI = BASE_LSB - VEC_W - ALIGN_BITS;

    logic [XLEN-1:0]  aligned;
    logic [FMT_W-1:0] fmt;

    always_comb begin
        aligned  = {ssp[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        fmt      = FMT_W'(WORD_BYTES) + FMT_W'(ssp[ALIGN_BITS-1:0]);
        pc_slot  = aligned - XLEN'(WORD_BYTES);
        fv_slot  = aligned - XLEN'(2 * WORD_BYTES);
        fv_word  = {fmt, {PAD_W{1'b0}}, vec, sr};
        vec_addr = {vbr[XLEN-1:BASE_LSB], {IDX_HI{1'b0}}, vec, {ALIGN_BITS{1'b0}}};
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int FIRST_PERIPH = 64,
    parameter int LAST_VALID   = 102
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [XLEN-1:0]  fault_pc,
    input  logic [XLEN-1:0]  next_pc,
    input  logic [SR_W-1:0]  sr_in,
    input  logic [XLEN-1:0]  ssp_in,
    input  logic [XLEN-1:0]  vbr_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [XLEN-1:0]  ssp_out,
    output logic             vec_error
);
    seq_state_e      state_q, state_d;
    exc_req_t        req_q;
    logic [XLEN-1:0] pc_slot_q, fv_slot_q, fv_word_q, vec_addr_q, handler_q;
    logic            err_q;

    logic [XLEN-1:0] sel_pc;
    logic            sel_bad;
    logic [XLEN-1:0] gen_pc_slot, gen_fv_slot, gen_fv_word, gen_vec_addr;
    logic            take;

    exc_pc_select #(
        .FIRST_PERIPH (FIRST_PERIPH),
        .LAST_VALID   (LAST_VALID)
    ) u_pc_select (
        .vec        (req_vector),
        .fault_pc   (fault_pc),
        .next_pc    (next_pc),
        .stacked_pc (sel_pc),
        .vec_bad    (sel_bad)
    );

    exc_frame_gen u_frame_gen (
        .ssp      (req_q.ssp),
        .vbr      (req_q.vbr),
        .vec      (req_q.vec),
        .sr       (req_q.sr),
        .pc_slot  (gen_pc_slot),
        .fv_slot  (gen_fv_slot),
        .fv_word  (gen_fv_word),
        .vec_addr (gen_vec_addr)
    );

    assign take = req_valid && (state_q == ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (take && !sel_bad) state_d = ST_ALIGN;
            ST_ALIGN:       state_d = ST_PUSH_PC;
            ST_PUSH_PC:     if (mem_ready) state_d = ST_PUSH_SR;
            ST_PUSH_SR:     if (mem_ready) state_d = ST_READ_VECTOR;
            ST_READ_VECTOR: if (mem_ready) state_d = ST_REDIRECT;
            ST_REDIRECT:    state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            pc_slot_q  <= '0;
            fv_slot_q  <= '0;
            fv_word_q  <= '0;
            vec_addr_q <= '0;
            handler_q  <= '0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= take && sel_bad;
            if (take && !sel_bad) begin
                req_q.vec <= req_vector;
                req_q.pc  <= sel_pc;
                req_q.sr  <= sr_in;
                req_q.ssp <= ssp_in;
                req_q.vbr <= vbr_in;
            end
            if (state_q == ST_ALIGN) begin
                pc_slot_q  <= gen_pc_slot;
                fv_slot_q  <= gen_fv_slot;
                fv_word_q  <= gen_fv_word;
                vec_addr_q <= gen_vec_addr;
            end
            if (state_q == ST_READ_VECTOR && mem_ready) begin
                handler_q <= mem_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready      = 1'b0;
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = '0;
        mem_wdata      = '0;
        redirect_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:        req_ready = 1'b1;
            ST_ALIGN:       ;
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pc_slot_q;
                mem_wdata = req_q.pc;
            end
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fv_slot_q;
                mem_wdata = fv_word_q;
            end
            ST_READ_VECTOR: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr_q;
            end
            ST_REDIRECT:    redirect_valid = 1'b1;
            default:        ;
        endcase
        redirect_pc = handler_q;
        ssp_out     = fv_slot_q;
        vec_error   = err_q;
    end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_entry_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ready,
    input logic            redirect_valid,
    input logic [XLEN-1:0] ssp_out,
    input logic            vec_error
);
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ALIGN_BITS-1:0] == '0)); // R7

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req); // R2

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (!redirect_valid && req_ready)); // R8

    AST_SSP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (ssp_out[ALIGN_BITS-1:0] == '0)); // R8

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        vec_error |-> (!mem_req && req_ready && !redirect_valid)); // R9

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_error |=> !vec_error); // R9
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ready      (mem_ready),
    .redirect_valid (redirect_valid),
    .ssp_out        (ssp_out),
    .vec_error      (vec_error)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_vector = '0;
    logic [31:0] fault_pc = '0, next_pc = '0, ssp_in = '0, vbr_in = '0;
    logic [15:0] sr_in = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        redirect_valid;
    logic [31:0] redirect_pc, ssp_out;
    logic        vec_error;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .fault_pc(fault_pc), .next_pc(next_pc),
        .sr_in(sr_in), .ssp_in(ssp_in), .vbr_in(vbr_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .ssp_out(ssp_out), .vec_error(vec_error)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] table_data(input logic [31:0] a);
        return {~a[15:0], a[15:2], 2'b10};
    endfunction

    // Serve one access: wait for mem_req, check it, stall, acknowledge.
    task automatic serve(input bit exp_we, input logic [31:0] exp_addr, input logic [31:0] exp_wdata,
                         input int waits, input string req);
        int guard = 0;
        while (!mem_req && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        check(mem_req === 1'b1, req, {31'b0, mem_req}, 32'h1);
        check(mem_addr === exp_addr, req, mem_addr, exp_addr);
        check(mem_we === exp_we, req, {31'b0, mem_we}, {31'b0, exp_we});
        if (exp_we) check(mem_wdata === exp_wdata, req, mem_wdata, exp_wdata);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            check(mem_req === 1'b1 && mem_addr === exp_addr && mem_we === exp_we, "R7",
                  mem_addr, exp_addr);
        end
        mem_ready = 1'b1;
        mem_rdata = exp_we ? 32'hDEAD_BEEF : table_data(exp_addr);
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = '0;
    endtask

    task automatic run_exc(input int v, input int off, input int waits, input bit contend);
        logic [31:0] fpc, npc, ssp, vbr, aligned, exp_pc, fvw, vaddr;
        logic [15:0] sr;
        bit          is_next, bad;
        fpc = 32'h1000_0000 + 32'(v * 6);
        npc = 32'h2000_0000 + 32'(v * 6);
        sr  = 16'h2700 ^ 16'(v * 5);
        ssp = 32'h0080_4000 + 32'(v * 16) + 32'(off);
        vbr = (32'(v % 16) << 20) | 32'h0000_0000 | (32'h000A_BC00 + 32'(v * 3));
        is_next = (v == 9) || (v == 12) || (v == 24) || (v >= 64 && v <= 102);
        bad     = (v < 2) || (v > 102);
        aligned = ssp & 32'hFFFF_FFFC;
        exp_pc  = is_next ? npc : fpc;
        fvw     = {4'(4 + off), 4'h0, 8'(v), sr};
        vaddr   = {vbr[31:20], 10'b0, 8'(v), 2'b00};

        check(req_ready === 1'b1, "R2", {31'b0, req_ready}, 32'h1);
        req_valid  = 1'b1;
        req_vector = 8'(v);
        fault_pc = fpc; next_pc = npc; sr_in = sr; ssp_in = ssp; vbr_in = vbr;
        @(negedge clk);
        if (bad) begin
            req_valid = 1'b0;
            check(vec_error === 1'b1, "R9", {31'b0, vec_error}, 32'h1);
            check(req_ready === 1'b1 && mem_req === 1'b0, "R9", {30'b0, req_ready, mem_req}, 32'h2);
            @(negedge clk);
            check(vec_error === 1'b0 && mem_req === 1'b0 && redirect_valid === 1'b0, "R9",
                  {29'b0, vec_error, mem_req, redirect_valid}, 32'h0);
            return;
        end
        check(req_ready === 1'b0, "R2", {31'b0, req_ready}, 32'h0);
        if (contend) begin
            // competing request held during the whole busy period
            req_vector = 8'd70; fault_pc = 32'hBAD0_0001; next_pc = 32'hBAD0_0002;
            sr_in = 16'hFFFF; ssp_in = 32'h0000_0103; vbr_in = 32'hFFF0_0000;
        end else begin
            req_valid = 1'b0;
        end
        serve(1'b1, aligned - 32'd4, exp_pc, waits, is_next ? "R4 R3" : "R3 R4");
        serve(1'b1, aligned - 32'd8, fvw, waits, "R5");
        serve(1'b0, vaddr, 32'h0, waits, "R6");
        req_valid = 1'b0;
        check(redirect_valid === 1'b1, "R8", {31'b0, redirect_valid}, 32'h1);
        check(redirect_pc === table_data(vaddr), "R8", redirect_pc, table_data(vaddr));
        check(ssp_out === aligned - 32'd8, "R8", ssp_out, aligned - 32'd8);
        @(negedge clk);
        check(redirect_valid === 1'b0 && req_ready === 1'b1, "R8",
              {30'b0, redirect_valid, req_ready}, 32'h1);
        check(mem_req === 1'b0, contend ? "R2" : "R8", {31'b0, mem_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b1 && mem_req === 1'b0 && redirect_valid === 1'b0 && vec_error === 1'b0,
              "R1", {28'b0, req_ready, mem_req, redirect_valid, vec_error}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && mem_req === 1'b0, "R1", {30'b0, req_ready, mem_req}, 32'h2);
        for (int v = 0; v < 256; v++) begin
            run_exc(v, v % 4, v % 3, (v % 5) == 0);
        end
        // all misalignments on a fault-PC and a next-PC vector with long stalls
        for (int off = 0; off < 4; off++) begin
            run_exc(4, off, 5, 1'b0);
            run_exc(64, off, 4, 1'b1);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule